// File: doc/BRIEF.md
# Lockable SMM memory range decoder

This block holds one 8-bit control byte that sets aside system-management (SMM) memory and graphics frame-buffer memory. It uses that byte to route every processor-side memory request to one of three targets: main DRAM, the internal graphics engine, or the downstream hub port. Three 2-bit fields in the byte make the choices. The graphics field enables the graphics engine and reserves 0, 512 KB or 1 MB for it. The upper field controls a reserved segment at the top of DRAM and a high alias of the legacy video window. The lower field controls how the legacy A0000–BFFFF window is served.

The block also reports the top of memory that remains usable once both reservations are taken. The top-segment reservation is taken first, just under the physical top. The graphics reservation is taken directly beneath it.

A sticky lock, set by a one-cycle strobe and cleared only by reset, freezes the byte. The one exception is the lowest bit of the lower field, which stays writable while the bit above it holds 1. Address decode is combinational. Its result is captured one cycle after a request strobe.

Top module: `smm_range_decoder`

## Requirements
- R1: After reset the control byte reads 8'h00, the lock is clear, `route_valid` is 0, `gfx_en` is 0 and `usable_top` equals `MEM_TOP`.
- R2: While unlocked, a write (`cfg_we`=1) loads all 8 bits of `cfg_wdata`, and the new value is visible on `cfg_rdata` the next cycle. Byte layout: [7:6] graphics field, [5:4] upper field, [3:2] lower field, [1:0] unused, held at 0.
- R3: A `lock_set` pulse locks the byte until the next reset. A write issued in the same cycle as the pulse still completes as an unlocked write. After a reset the byte is writable again.
- R4: While locked, bits 7:3 ignore writes.
- R5: While locked, bit 2 takes the written value only if bit 3 currently holds 1. Otherwise bit 2 is held.
- R6: `gfx_en` is 1 when the graphics field is nonzero. The reservation sizes are: upper field 10 gives 512 KB and 11 gives 1 MB; graphics field 10 gives 512 KB and 11 gives 1 MB; every other code gives 0. `usable_top` = `MEM_TOP` − top-segment size − graphics size.
- R7: `route_valid` follows `req_valid` one clock later, and `route` holds the decision for the request sampled in that cycle. Route encoding: 0 = DRAM, 1 = graphics, 2 = hub.
- R8: Handling of A0000–BFFFF by lower field:
  - 00: never DRAM.
  - 01: always DRAM.
  - 10: DRAM only for a read (`req_write`=0) that is code (`req_code`=1) from the processor (`req_cpu`=1) in SMM (`smm_mode`=1).
  - 11: DRAM for any processor access in SMM.
- R9: An A0000–BFFFF request that R8 does not send to DRAM goes to graphics when the graphics field is nonzero, and to the hub otherwise.
- R10: When the upper field is 10 or 11, requests in [`MEM_TOP` − size, `MEM_TOP`) go to DRAM only for processor accesses in SMM. All other requests in that range go to the hub.
- R11: The window FEEA0000–FEEBFFFF is active only when the upper field is nonzero and the lower field is 00. In that state a processor access in SMM goes to DRAM and any other access goes to the hub. When the window is inactive, requests there follow R12.
- R12: Any other request goes to DRAM if its address is below `usable_top`, and to the hub otherwise. This includes requests into the graphics reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| lock_set | input | 1 | Sets the sticky lock |
| cfg_rdata | output | 8 | Current control byte |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_code | input | 1 | 1 = instruction fetch |
| req_cpu | input | 1 | 1 = processor initiator |
| smm_mode | input | 1 | Processor is in SMM |
| route_valid | output | 1 | Decision valid |
| route | output | 2 | 0 DRAM, 1 graphics, 2 hub |
| usable_top | output | ADDR_W | Top of usable DRAM after reservations |
| gfx_en | output | 1 | Graphics engine enabled |

## Verification
The hardest state to reach is a locked byte in which bit 3 holds 1 but bit 2 still has to toggle. Reaching it requires an unlocked write that sets bit 3, then the lock, then writes whose data disagrees with the frozen upper bits. The bench builds that exact sequence. It also issues a lock together with a write in the same cycle, and repeats the sequence with bit 3 clear. Routing is swept exhaustively over all 256 byte values, all 16 flag combinations, and addresses placed on every window edge.

// File: rtl/smm_pkg.sv
package smm_pkg;

  typedef enum logic [1:0] {
    ROUTE_DRAM = 2'd0,
    ROUTE_GFX  = 2'd1,
    ROUTE_HUB  = 2'd2
  } route_e;

  typedef struct packed {
    logic [1:0] gfx_sel;
    logic [1:0] upper_sel;
    logic [1:0] lower_sel;
    logic [1:0] spare;
  } ctrl_t;

  localparam int unsigned HALF_MB_SHIFT = 19;

endpackage

// File: rtl/smm_ctrl_reg.sv
module smm_ctrl_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_wdata,
  input  logic        lock_set,
  output smm_pkg::ctrl_t ctrl_q,
  output logic        locked_q
);
  import smm_pkg::*;

  ctrl_t ctrl_d;
  logic  locked_d;
  logic  reg_en;

  always_comb begin
    ctrl_d   = ctrl_q;
    locked_d = locked_q | lock_set;
    reg_en   = cfg_we | lock_set;
    if (cfg_we) begin
      if (!locked_q) begin
        ctrl_d       = ctrl_t'(cfg_wdata);
        ctrl_d.spare = 2'b00;
      end else if (ctrl_q.lower_sel[1]) begin
        ctrl_d.lower_sel[0] = cfg_wdata[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else if (reg_en) begin
      ctrl_q   <= ctrl_d;
      locked_q <= locked_d;
    end
  end

endmodule

// File: rtl/smm_carve_calc.sv
module smm_carve_calc #(
  parameter int unsigned       ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] MEM_TOP = 32'h0400_0000
) (
  input  smm_pkg::ctrl_t    ctrl,
  output logic [ADDR_W-1:0] top_seg_base,
  output logic              top_seg_on,
  output logic [ADDR_W-1:0] usable_top,
  output logic              gfx_en
);
  import smm_pkg::*;

  localparam logic [ADDR_W-1:0] SZ_HALF = ADDR_W'(1) << HALF_MB_SHIFT;
  localparam logic [ADDR_W-1:0] SZ_FULL = ADDR_W'(1) << (HALF_MB_SHIFT + 1);

  logic [ADDR_W-1:0] top_sz;
  logic [ADDR_W-1:0] gfx_sz;

  function automatic logic [ADDR_W-1:0] size_of(input logic [1:0] sel);
    case (sel)
      2'b10:   size_of = SZ_HALF;
      2'b11:   size_of = SZ_FULL;
      default: size_of = '0;
    endcase
  endfunction

  always_comb begin
    top_sz       = size_of(ctrl.upper_sel);
    gfx_sz       = size_of(ctrl.gfx_sel);
    top_seg_on   = ctrl.upper_sel[1];
    top_seg_base = MEM_TOP - top_sz;
    usable_top   = top_seg_base - gfx_sz;
    gfx_en       = |ctrl.gfx_sel;
  end

endmodule

// File: rtl/smm_addr_decode.sv
module smm_addr_decode #(
  parameter int unsigned       ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] MEM_TOP  = 32'h0400_0000,
  parameter logic [ADDR_W-1:0] LEG_LO   = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] LEG_HI   = 32'h000B_FFFF,
  parameter logic [ADDR_W-1:0] ALIAS_LO = 32'hFEEA_0000,
  parameter logic [ADDR_W-1:0] ALIAS_HI = 32'hFEEB_FFFF
) (
  input  smm_pkg::ctrl_t    ctrl,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  input  logic              is_code,
  input  logic              is_cpu,
  input  logic              in_smm,
  input  logic [ADDR_W-1:0] top_seg_base,
  input  logic              top_seg_on,
  input  logic [ADDR_W-1:0] usable_top,
  input  logic              gfx_en,
  output smm_pkg::route_e   route_d
);
  import smm_pkg::*;

  logic smm_cpu;
  logic hit_leg, hit_alias, hit_top;
  logic leg_dram;
  logic alias_on;

  always_comb begin
    smm_cpu   = in_smm & is_cpu;
    hit_leg   = (addr >= LEG_LO) && (addr <= LEG_HI);
    hit_alias = (addr >= ALIAS_LO) && (addr <= ALIAS_HI);
    hit_top   = top_seg_on && (addr >= top_seg_base) && (addr < MEM_TOP);
    alias_on  = (ctrl.upper_sel != 2'b00) && (ctrl.lower_sel == 2'b00);

    case (ctrl.lower_sel)
      2'b01:   leg_dram = 1'b1;
      2'b10:   leg_dram = smm_cpu & is_code & ~is_write;
      2'b11:   leg_dram = smm_cpu;
      default: leg_dram = 1'b0;
    endcase

    if (hit_leg) begin
      route_d = leg_dram ? ROUTE_DRAM : (gfx_en ? ROUTE_GFX : ROUTE_HUB);
    end else if (hit_alias && alias_on) begin
      route_d = smm_cpu ? ROUTE_DRAM : ROUTE_HUB;
    end else if (hit_top) begin
      route_d = smm_cpu ? ROUTE_DRAM : ROUTE_HUB;
    end else if (addr < usable_top) begin
      route_d = ROUTE_DRAM;
    end else begin
      route_d = ROUTE_HUB;
    end
  end

endmodule

// File: rtl/smm_range_decoder.sv
module smm_range_decoder #(
  parameter int unsigned       ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] MEM_TOP = 32'h0400_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              lock_set,
  output logic [7:0]        cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_code,
  input  logic              req_cpu,
  input  logic              smm_mode,
  output logic              route_valid,
  output logic [1:0]        route,
  output logic [ADDR_W-1:0] usable_top,
  output logic              gfx_en
);
  import smm_pkg::*;

  ctrl_t             ctrl_q;
  logic              locked_q;
  logic [ADDR_W-1:0] top_seg_base;
  logic              top_seg_on;
  route_e            route_d;
  route_e            route_q;
  logic              route_valid_q;

  smm_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .lock_set (lock_set),
    .ctrl_q   (ctrl_q),
    .locked_q (locked_q)
  );

  smm_carve_calc #(.ADDR_W(ADDR_W), .MEM_TOP(MEM_TOP)) u_carve (
    .ctrl        (ctrl_q),
    .top_seg_base(top_seg_base),
    .top_seg_on  (top_seg_on),
    .usable_top  (usable_top),
    .gfx_en      (gfx_en)
  );

  smm_addr_decode #(.ADDR_W(ADDR_W), .MEM_TOP(MEM_TOP)) u_dec (
    .ctrl        (ctrl_q),
    .addr        (req_addr),
    .is_write    (req_write),
    .is_code     (req_code),
    .is_cpu      (req_cpu),
    .in_smm      (smm_mode),
    .top_seg_base(top_seg_base),
    .top_seg_on  (top_seg_on),
    .usable_top  (usable_top),
    .gfx_en      (gfx_en),
    .route_d     (route_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_valid_q <= 1'b0;
    end else begin
      route_valid_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= ROUTE_DRAM;
    end else if (req_valid) begin
      route_q <= route_d;
    end
  end

  assign cfg_rdata   = ctrl_q;
  assign route_valid = route_valid_q;
  assign route       = route_q;

endmodule

// File: rtl/smm_range_decoder_chk.sv
module smm_range_decoder_chk #(
  parameter int unsigned       ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] MEM_TOP = 32'h0400_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              locked,
  input logic [7:0]        cfg_rdata,
  input logic              req_valid,
  input logic              route_valid,
  input logic [1:0]        route,
  input logic [ADDR_W-1:0] usable_top
);

  localparam logic [ADDR_W-1:0] MAX_CARVE = ADDR_W'(1) << 21;

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  assert_upper_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> cfg_rdata[7:3] == $past(cfg_rdata[7:3]));

  assert_bit2_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !cfg_rdata[3]) |=> $stable(cfg_rdata[2]));

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> route_valid);

  assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !route_valid);

  assert_route_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |-> route != 2'b11);

  assert_top_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (usable_top <= MEM_TOP) && (usable_top >= MEM_TOP - MAX_CARVE));

endmodule

bind smm_range_decoder smm_range_decoder_chk #(.ADDR_W(ADDR_W), .MEM_TOP(MEM_TOP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .locked     (locked_q),
  .cfg_rdata  (cfg_rdata),
  .req_valid  (req_valid),
  .route_valid(route_valid),
  .route      (route),
  .usable_top (usable_top)
);

// File: tb/smm_range_decoder_bench.sv
module smm_range_decoder_bench;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] TOP        = 32'h0400_0000;
  localparam int          NVEC       = 18;

  // {ctrl byte, {smm, code, cpu, write}, address, expected route}
  localparam logic [45:0] VEC [NVEC] = '{
    {8'h00, 4'b0000, 32'h000A_0000, 2'd2},
    {8'h40, 4'b0010, 32'h000A_0000, 2'd1},
    {8'h04, 4'b0001, 32'h000B_0000, 2'd0},
    {8'h08, 4'b1110, 32'h000A_8000, 2'd0},
    {8'h08, 4'b1010, 32'h000A_8000, 2'd2},
    {8'h08, 4'b1111, 32'h000A_8000, 2'd2},
    {8'h0C, 4'b1011, 32'h000B_FFFF, 2'd0},
    {8'h4C, 4'b0010, 32'h000B_FFFF, 2'd1},
    {8'h30, 4'b0010, 32'h03F0_0000, 2'd2},
    {8'h30, 4'b1010, 32'h03FF_FFFF, 2'd0},
    {8'h30, 4'b1000, 32'h03F8_0000, 2'd2},
    {8'h10, 4'b1010, 32'hFEEA_0000, 2'd0},
    {8'h14, 4'b1010, 32'hFEEA_0000, 2'd2},
    {8'hF0, 4'b0010, 32'h03E0_0000, 2'd2},
    {8'hF0, 4'b0010, 32'h03DF_FFFF, 2'd0},
    {8'h00, 4'b0010, 32'h0010_0000, 2'd0},
    {8'h20, 4'b0010, 32'h03F7_FFFF, 2'd0},
    {8'h20, 4'b0010, 32'h03F8_0000, 2'd2}
  };

  localparam logic [31:0] SWEEP_ADDR [8] = '{
    32'h000A_0000, 32'h000B_FFFF, 32'hFEEA_0000, 32'hFEEB_FFFF,
    32'h03F0_0000, 32'h03F8_0000, 32'h03E8_0000, 32'h0000_0100
  };

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic        lock_set;
  logic [7:0]  cfg_rdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_write, req_code, req_cpu, smm_mode;
  logic        route_valid;
  logic [1:0]  route;
  logic [31:0] usable_top;
  logic        gfx_en;

  int n_tests;
  int n_fail;
  bit done;

  smm_range_decoder #(.ADDR_W(32), .MEM_TOP(TOP)) u_smm_range_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .lock_set(lock_set), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_code(req_code),
    .req_cpu(req_cpu), .smm_mode(smm_mode), .route_valid(route_valid),
    .route(route), .usable_top(usable_top), .gfx_en(gfx_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] ref_size(input logic [1:0] sel);
    if (sel == 2'b10) return 32'h0008_0000;
    if (sel == 2'b11) return 32'h0010_0000;
    return 32'h0;
  endfunction

  function automatic logic [31:0] ref_top(input logic [7:0] c);
    return TOP - ref_size(c[5:4]) - ref_size(c[7:6]);
  endfunction

  function automatic logic [1:0] ref_route(input logic [7:0] c, input logic [3:0] f,
                                           input logic [31:0] a);
    logic smm_ok, dram;
    logic [31:0] ts;
    smm_ok = f[3] && f[1];
    if (a >= 32'h000A_0000 && a <= 32'h000B_FFFF) begin
      dram = (c[3:2] == 2'b01) || (c[3:2] == 2'b11 && smm_ok) ||
             (c[3:2] == 2'b10 && smm_ok && f[2] && !f[0]);
      if (dram) return 2'd0;
      return (c[7:6] != 2'b00) ? 2'd1 : 2'd2;
    end
    if (a >= 32'hFEEA_0000 && a <= 32'hFEEB_FFFF && c[5:4] != 2'b00 && c[3:2] == 2'b00)
      return smm_ok ? 2'd0 : 2'd2;
    ts = ref_size(c[5:4]);
    if (ts != 0 && a >= TOP - ts && a < TOP)
      return smm_ok ? 2'd0 : 2'd2;
    return (a < ref_top(c)) ? 2'd0 : 2'd2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] d, input logic lk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d; lock_set = lk;
    @(negedge clk);
    cfg_we = 1'b0; lock_set = 1'b0;
  endtask

  task automatic do_req(input logic [3:0] f, input logic [31:0] a, output logic [1:0] r,
                        output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    smm_mode = f[3]; req_code = f[2]; req_cpu = f[1]; req_write = f[0];
    @(negedge clk);
    req_valid = 1'b0;
    r = route; v = route_valid;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] r;
    logic       v;
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; lock_set = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_code = 1'b0;
    req_cpu = 1'b0; smm_mode = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ctrl", {24'h0, cfg_rdata}, 32'h0);
    check("R1 valid", {31'h0, route_valid}, 32'h0);
    check("R1 gfx_en", {31'h0, gfx_en}, 32'h0);
    check("R1 top", usable_top, TOP);

    // R8 R9 R10 R11 R12 directed table
    for (int i = 0; i < NVEC; i++) begin
      wr_cfg(VEC[i][45:38], 1'b0);
      do_req(VEC[i][37:34], VEC[i][33:2], r, v);
      check("R7 valid", {31'h0, v}, 32'h1);
      check("R8-table route", {30'h0, r}, {30'h0, VEC[i][1:0]});
    end

    // R2 R6 R7 exhaustive sweep against reference model
    for (int c = 0; c < 256; c++) begin
      wr_cfg(8'(c), 1'b0);
      check("R2 readback", {24'h0, cfg_rdata}, {24'h0, 8'(c) & 8'hFC});
      check("R6 top", usable_top, ref_top(8'(c)));
      check("R6 gfx_en", {31'h0, gfx_en}, {31'h0, (8'(c) >> 6) != 0});
      for (int a = 0; a < 8; a++) begin
        for (int f = 0; f < 16; f++) begin
          do_req(4'(f), SWEEP_ADDR[a], r, v);
          check("R7 sweep route", {30'h0, r}, {30'h0, ref_route(8'(c), 4'(f), SWEEP_ADDR[a])});
        end
      end
    end

    // R7 no strobe -> valid low
    @(negedge clk);
    check("R7 idle", {31'h0, route_valid}, 32'h0);

    // R3 R4 R5 lock behaviour
    do_reset();
    check("R1 after reset", {24'h0, cfg_rdata}, 32'h0);
    wr_cfg(8'hAC, 1'b0);
    check("R2 unlocked", {24'h0, cfg_rdata}, 32'hAC);
    wr_cfg(8'hAC, 1'b1);
    wr_cfg(8'h53, 1'b0);
    check("R4 R5 locked write", {24'h0, cfg_rdata}, 32'hA8);
    wr_cfg(8'hFF, 1'b0);
    check("R5 bit2 set", {24'h0, cfg_rdata}, 32'hAC);
    wr_cfg(8'h00, 1'b0);
    check("R3 still locked", {24'h0, cfg_rdata}, 32'hA8);
    check("R6 locked top", usable_top, ref_top(8'hA8));

    do_reset();
    wr_cfg(8'h30, 1'b1);
    check("R3 same-cycle write", {24'h0, cfg_rdata}, 32'h30);
    wr_cfg(8'h04, 1'b0);
    check("R5 bit2 held", {24'h0, cfg_rdata}, 32'h30);
    wr_cfg(8'hCC, 1'b0);
    check("R4 upper held", {24'h0, cfg_rdata}, 32'h30);

    do_reset();
    wr_cfg(8'hFF, 1'b0);
    check("R3 reset unlocks", {24'h0, cfg_rdata}, 32'hFC);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule